// File: doc/BRIEF.md
# Palette Colour Table Loader

This block holds a 256-entry colour lookup table with separate 8-bit red, green and blue components. It also provides the 32-bit register port that software uses to fill the table. Software first writes an entry number to the index register. It then writes the colour components one at a time to the data register: red, then green, then blue. After each blue write the index moves on by one, so a whole table can be loaded with one index write followed by a stream of data writes.

The pixel pipeline reads any entry through a separate read port. This port has no wait states and returns the stored triple for the index it presents. Reset fills the table with black, except for the last entry, which becomes white. The register port accepts full 32-bit word accesses only. Reads always return zero, and any access outside the two active registers has no effect.

Top module: `pal_dac_port`

## Requirements
- R1: After reset every table entry reads 0/0/0 on the read port, except entry 255, which reads 255/255/255. The write index starts at 0 and the component sequence starts at red.
- R2: A full-word write (byte strobes 4'hF) to offset 0 loads the write index from bits 31:24 of the data. It also returns the component sequence to red, even partway through an entry.
- R3: Full-word writes to offset 4 store bits 31:24 of the data into red, green and blue of the current entry, in that order, one component per write.
- R4: The third component write (blue) advances the write index by one and returns the sequence to red. The index wraps from 255 to 0.
- R5: Reads from any offset return zero on the read data bus.
- R6: Writes to offsets other than 0 and 4 in the 16-byte window change neither the table, the index nor the sequence.
- R7: A write whose byte strobes are not all ones has no effect on the table, the index or the sequence, even at offset 0 or 4.
- R8: A component written at a clock edge appears on the read port from that edge onward and not before. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset within the 16-byte register window |
| be_i | input | 4 | Byte strobes; only 4'hF is a valid access |
| wdata_i | input | 32 | Write data; bits 31:24 carry the index or component |
| rdata_o | output | 32 | Read data, always zero |
| rd_idx_i | input | 8 | Pixel pipeline lookup index |
| rd_red_o | output | 8 | Red component of the addressed entry |
| rd_grn_o | output | 8 | Green component of the addressed entry |
| rd_blu_o | output | 8 | Blue component of the addressed entry |

## Verification
The assertions assume that each access is held for a single clock cycle and treated as one transfer, with no bus stalls. They also assume that the read-port visibility property only applies while the lookup index does not change across the write edge; the property itself excuses cycles where it moves. The bench drives one access per cycle, changing requests only on the falling edge, and keeps the lookup index still around every write it checks for visibility. It also places index reloads, sub-word strobes and stray offsets between data writes, so that the sequence state is tested at every phase.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef enum logic [1:0] {
    SEL_RED = 2'd0,
    SEL_GRN = 2'd1,
    SEL_BLU = 2'd2
  } comp_sel_e;
endpackage

// File: rtl/pal_dac_decode.sv
module pal_dac_decode #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int COMP_W  = 8,
  parameter int IDX_OFF = 0,
  parameter int DAT_OFF = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic [COMP_W-1:0] field_o
);
  logic full_wr;
  logic unused_low;

  assign full_wr    = req_i && we_i && (be_i == '1);
  assign idx_wr_o   = full_wr && (addr_i == IDX_OFF[ADDR_W-1:0]);
  assign dat_wr_o   = full_wr && (addr_i == DAT_OFF[ADDR_W-1:0]);
  // payload rides in the top byte lane
  assign field_o    = wdata_i[DATA_W-1 -: COMP_W];
  assign unused_low = ^wdata_i[DATA_W-COMP_W-1:0];
endmodule

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic              dat_wr_i,
  input  logic [COMP_W-1:0] field_i,
  output logic [IDX_W-1:0]  idx_o,
  output comp_sel_e         sel_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  comp_sel_e        sel_q, sel_d;
  logic unused_field_hi;

  assign unused_field_hi = (COMP_W > IDX_W) ? ^field_i : 1'b0;

  always_comb begin
    idx_d = idx_q;
    sel_d = sel_q;
    if (idx_wr_i) begin
      idx_d = field_i[IDX_W-1:0];
      sel_d = SEL_RED;
    end else if (dat_wr_i) begin
      unique case (sel_q)
        SEL_RED: sel_d = SEL_GRN;
        SEL_GRN: sel_d = SEL_BLU;
        default: begin
          sel_d = SEL_RED;
          idx_d = idx_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sel_q <= SEL_RED;
    end else begin
      idx_q <= idx_d;
      sel_q <= sel_d;
    end
  end

  assign idx_o = idx_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/pal_dac_table.sv
module pal_dac_table
  import pal_dac_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int COMP_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  comp_sel_e         wr_sel_i,
  input  logic [COMP_W-1:0] wr_val_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [COMP_W-1:0] rd_red_o,
  output logic [COMP_W-1:0] rd_grn_o,
  output logic [COMP_W-1:0] rd_blu_o
);
  logic [COMP_W-1:0] red_q [ENTRIES];
  logic [COMP_W-1:0] grn_q [ENTRIES];
  logic [COMP_W-1:0] blu_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [COMP_W-1:0] INIT = (e == ENTRIES - 1) ? '1 : '0;
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == e[IDX_W-1:0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        red_q[e] <= INIT;
        grn_q[e] <= INIT;
        blu_q[e] <= INIT;
      end else if (hit) begin
        if (wr_sel_i == SEL_RED) red_q[e] <= wr_val_i;
        if (wr_sel_i == SEL_GRN) grn_q[e] <= wr_val_i;
        if (wr_sel_i == SEL_BLU) blu_q[e] <= wr_val_i;
      end
    end
  end

  assign rd_red_o = red_q[rd_idx_i];
  assign rd_grn_o = grn_q[rd_idx_i];
  assign rd_blu_o = blu_q[rd_idx_i];
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
  import pal_dac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int ENTRIES = 256,
  parameter int COMP_W  = 8,
  parameter int IDX_OFF = 0,
  parameter int DAT_OFF = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [COMP_W-1:0] rd_red_o,
  output logic [COMP_W-1:0] rd_grn_o,
  output logic [COMP_W-1:0] rd_blu_o
);
  logic              idx_wr, dat_wr;
  logic [COMP_W-1:0] field;
  logic [IDX_W-1:0]  idx_q;
  comp_sel_e         seq_q;

  pal_dac_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COMP_W(COMP_W),
    .IDX_OFF(IDX_OFF), .DAT_OFF(DAT_OFF)
  ) u_decode (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .idx_wr_o(idx_wr), .dat_wr_o(dat_wr), .field_o(field)
  );

  pal_dac_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_wr_i(idx_wr), .dat_wr_i(dat_wr),
    .field_i(field), .idx_o(idx_q), .sel_o(seq_q)
  );

  pal_dac_table #(.ENTRIES(ENTRIES), .COMP_W(COMP_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(dat_wr), .wr_idx_i(idx_q),
    .wr_sel_i(seq_q), .wr_val_i(field), .rd_idx_i(rd_idx_i),
    .rd_red_o(rd_red_o), .rd_grn_o(rd_grn_o), .rd_blu_o(rd_blu_o)
  );

  // register port is write-only
  assign rdata_o = '0;
endmodule

// File: rtl/pal_dac_port_chk.sv
module pal_dac_port_chk
  import pal_dac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int COMP_W  = 8,
  parameter int IDX_W   = 8,
  parameter int IDX_OFF = 0,
  parameter int DAT_OFF = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W/8-1:0] be_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic [COMP_W-1:0] rd_red_o,
  input logic [IDX_W-1:0]  idx_q,
  input comp_sel_e         seq_q
);
  logic full_wr, wr_idx, wr_dat, wr_void;
  assign full_wr = req_i && we_i && (be_i == '1);
  assign wr_idx  = full_wr && (addr_i == IDX_OFF[ADDR_W-1:0]);
  assign wr_dat  = full_wr && (addr_i == DAT_OFF[ADDR_W-1:0]);
  assign wr_void = req_i && we_i && !wr_idx && !wr_dat;

  // R2
  a_r2_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_idx |=> (idx_q == $past(wdata_i[DATA_W-1 -: IDX_W])) && (seq_q == SEL_RED));

  // R3
  a_r3_red_to_green: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && seq_q == SEL_RED) |=> (seq_q == SEL_GRN) && $stable(idx_q));

  a_r3_green_to_blue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && seq_q == SEL_GRN) |=> (seq_q == SEL_BLU) && $stable(idx_q));

  // R4
  a_r4_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && seq_q == SEL_BLU) |=>
      (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (seq_q == SEL_RED));

  // R6, R7
  a_r6_r7_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_void |=> $stable(idx_q) && $stable(seq_q));

  // R8
  a_r8_red_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && seq_q == SEL_RED && rd_idx_i == idx_q) |=>
      (rd_idx_i != $past(rd_idx_i)) || (rd_red_o == $past(wdata_i[DATA_W-1 -: COMP_W])));
endmodule

bind pal_dac_port pal_dac_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COMP_W(COMP_W), .IDX_W(IDX_W),
  .IDX_OFF(IDX_OFF), .DAT_OFF(DAT_OFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i), .rd_idx_i(rd_idx_i),
  .rd_red_o(rd_red_o), .idx_q(idx_q), .seq_q(seq_q)
);

// File: tb/pal_dac_port_bench.sv
`timescale 1ns/1ps
module pal_dac_port_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0, be_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [7:0]  rd_idx_i = '0, rd_red_o, rd_grn_o, rd_blu_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_r [256], m_g [256], m_b [256];
  logic [7:0] m_idx;
  int         m_seq;

  always #2.5 clk = ~clk;

  pal_dac_port u_pal_dac_port (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rd_idx_i(rd_idx_i),
    .rd_red_o(rd_red_o), .rd_grn_o(rd_grn_o), .rd_blu_o(rd_blu_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_entry(string tag, int e);
    rd_idx_i = 8'(e);
    #0.1;
    chk(tag, {8'h0, rd_red_o, rd_grn_o, rd_blu_o}, {8'h0, m_r[e], m_g[e], m_b[e]});
  endtask

  task automatic chk_all(string tag);
    for (int e = 0; e < 256; e++) chk_entry(tag, e);
  endtask

  // model of R2, R3, R4, R6, R7
  task automatic model_wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    if (be != 4'hF) return;
    if (a == 4'd0) begin
      m_idx = d[31:24];
      m_seq = 0;
    end else if (a == 4'd4) begin
      case (m_seq)
        0: m_r[m_idx] = d[31:24];
        1: m_g[m_idx] = d[31:24];
        default: m_b[m_idx] = d[31:24];
      endcase
      m_seq++;
      if (m_seq == 3) begin
        m_seq = 0;
        m_idx = m_idx + 8'd1;
      end
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; be_i = '0;
    model_wr(a, d, be);
  endtask

  task automatic bus_rd(logic [3:0] a);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; be_i = 4'hF;
    #0.5;
    chk("R5 read returns zero", rdata_o, 32'h0);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 256; e++) begin
      m_r[e] = (e == 255) ? 8'hFF : 8'h00;
      m_g[e] = m_r[e];
      m_b[e] = m_r[e];
    end
    m_idx = 0; m_seq = 0;
    #12 rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset contents
    chk_all("R1 reset table");
    // R1 index 0 / seq red: first data write lands in red of entry 0
    bus_wr(4'd4, 32'h11_000000, 4'hF);
    chk_entry("R1 reset index and sequence", 0);

    // R2, R3, R4 full sweep with autoincrement and wrap
    bus_wr(4'd0, 32'h00_000000, 4'hF);
    for (int e = 0; e < 256; e++) begin
      bus_wr(4'd4, {8'((e * 7 + 3) & 255), 24'h0}, 4'hF);
      bus_wr(4'd4, {8'(e) ^ 8'h5A, 24'h123456}, 4'hF);
      bus_wr(4'd4, {8'(255 - e), 24'h0}, 4'hF);
    end
    chk_all("R3 sweep contents");
    // R4 wrap 255->0 then red
    bus_wr(4'd4, 32'hC3_000000, 4'hF);
    chk_entry("R4 wrap to entry 0", 0);
    chk_entry("R4 wrap leaves 255", 255);

    // R2 index reload mid-sequence
    bus_wr(4'd0, 32'h0A_FFFFFF, 4'hF);
    bus_wr(4'd4, 32'hAA_000000, 4'hF);
    bus_wr(4'd0, 32'h14_000000, 4'hF);
    bus_wr(4'd4, 32'hBB_000000, 4'hF);
    bus_wr(4'd4, 32'hCC_000000, 4'hF);
    chk_entry("R2 reload keeps entry 10", 10);
    chk_entry("R2 reload restarts red", 20);

    // R7 sub-word accesses
    bus_wr(4'd0, 32'h1E_000000, 4'hF);
    bus_wr(4'd4, 32'h77_000000, 4'h7);
    bus_wr(4'd4, 32'h77_000000, 4'h8);
    bus_wr(4'd0, 32'h28_000000, 4'hE);
    chk_entry("R7 sub-word no table write", 30);
    bus_wr(4'd4, 32'h5C_000000, 4'hF);
    chk_entry("R7 sequence not advanced", 30);
    chk_entry("R7 index not reloaded", 40);

    // R6 other offsets
    for (int a = 1; a < 16; a++) begin
      if (a != 4) bus_wr(4'(a), {8'(a * 16 + 1), 24'h0}, 4'hF);
    end
    bus_wr(4'd4, 32'h6D_000000, 4'hF);
    chk_entry("R6 stray offsets ignored", 30);
    chk_all("R6 table unchanged");

    // R5 reads
    for (int a = 0; a < 16; a += 4) bus_rd(4'(a));

    // R8 visibility timing
    bus_wr(4'd0, 32'h50_000000, 4'hF);
    rd_idx_i = 8'h50;
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 4'd4; be_i = 4'hF; wdata_i = 32'hE1_000000;
    #0.5;
    chk("R8 not visible before edge", {24'h0, rd_red_o}, {24'h0, m_r[8'h50]});
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; be_i = '0;
    model_wr(4'd4, 32'hE1_000000, 4'hF);
    chk("R8 visible after edge", {24'h0, rd_red_o}, 32'hE1);
    chk_entry("R8 neighbour untouched", 8'h4F);
    chk_entry("R8 neighbour untouched", 8'h51);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule